// File: doc/BRIEF.md
# Cascaded CAM Chain Bring-Up Sequencer

This block sits on the host side of a string of cascaded content-addressable memory devices and produces, one bus cycle at a time, the command and data words that bring the whole string from power-up into normal operation. A single `start` pulse latches the chain length and a base page number. The sequencer then walks a fixed program.

The program opens with a dummy command read. It then turns off per-device selection and resets the string. Next it gives every device its own page address: it targets the page register, writes the page number and issues a set-full-flag command, which passes control to the next device in the string. When that loop is done it resets the string a second time. This clears the full flags but keeps the page addresses. Last come the operating control word, the segment-counter setup and the match-read mode command.

Each word is offered with `bus_valid` and moves on only when `bus_ready` is seen high. `bus_cmd` marks command cycles, and `bus_read` marks the one read cycle. `done` pulses after the final word has been taken. A start request whose page range would reach FFFFH, or whose chain length is zero, is refused with a one-cycle `err` pulse.

Top module: `cam_chain_init`

## Requirements
- R1: After reset, `bus_valid`, `done` and `err` are low, and they stay low until a start is accepted.
- R2: An accepted start makes `bus_valid` high from the next cycle. The first five words are: a command read (`bus_cmd`=1, `bus_read`=1, data 0000H), command 0100H (select Device Select register), data FFFFH, command 0101H (select Control register), data 0000H.
- R3: Next, for device i from 0 to N-1, three words are issued: command 0102H (select Page Address register), data `base_page`+i, and command 0200H (set full flag).
- R4: When N is 1, the set-full-flag word is left out and the loop issues only the two page words.
- R5: After the loop, seven words follow: command 0101H, data 0000H, command 0101H, data 8040H, command 0103H (select Segment Control register), data 3808H, command 0300H (read from segment 0 of the highest-priority match).
- R6: While `bus_valid` is high and `bus_ready` is low, the word, `bus_cmd` and `bus_read` hold steady. The sequence advances by exactly one word on each cycle where both are high.
- R7: `done` is high for exactly one cycle: the cycle after the last word is accepted. `bus_valid` is low in that cycle.
- R8: A start with N = 0, or with `base_page`+N-1 ≥ FFFFH, is refused. `err` pulses high for one cycle and no word is issued.
- R9: A `start` pulse while a sequence is running is ignored. The running sequence continues unchanged, and `done` is raised once.
- R10: `bus_read` is high only on the first word of the sequence, and `bus_read` high always comes with `bus_cmd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a sequence when idle |
| chain_len | input | CW | Number of devices in the string (N) |
| base_page | input | 16 | Page number given to the first device |
| bus_ready | input | 1 | Downstream takes the current word |
| bus_valid | output | 1 | A word is being offered |
| bus_cmd | output | 1 | 1 = command cycle, 0 = data cycle |
| bus_read | output | 1 | 1 = read cycle |
| bus_data | output | 16 | Command code or data word |
| done | output | 1 | One-cycle pulse after the last word |
| err | output | 1 | One-cycle pulse on a refused start |

## Verification
A wrong phase or sub-step shows up on `bus_data` in the very cycle it is offered. A wrong sub-step produces a command code where a data word belongs, and a wrong device counter produces a page number that is off by the error. A miscounted loop end shifts every later word, and it moves the `done` pulse early or late by a multiple of three cycles. A broken hold under back-pressure shows as a word that changes while `bus_ready` is low.

// File: rtl/cam_chain_init.sv
module cam_chain_init #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] chain_len,
  input  logic [15:0]   base_page,
  input  logic          bus_ready,
  output logic          bus_valid,
  output logic          bus_cmd,
  output logic          bus_read,
  output logic [15:0]   bus_data,
  output logic          done,
  output logic          err
);
  localparam logic [15:0] C_SEL_DSEL = 16'h0100;
  localparam logic [15:0] C_SEL_CTRL = 16'h0101;
  localparam logic [15:0] C_SEL_PAGE = 16'h0102;
  localparam logic [15:0] C_SEL_SEG  = 16'h0103;
  localparam logic [15:0] C_FULL_SET = 16'h0200;
  localparam logic [15:0] C_MATCH_RD = 16'h0300;
  localparam logic [15:0] V_ALL_ONES = 16'hFFFF;
  localparam logic [15:0] V_RUN_CTRL = 16'h8040;
  localparam logic [15:0] V_SEG_CTRL = 16'h3808;

  typedef enum logic [1:0] {P_IDLE, P_PRE, P_LOOP, P_POST} phase_t;

  phase_t        phase;
  logic [2:0]    sub;
  logic [CW-1:0] dev, len_q;
  logic [15:0]   base_q;
  logic          fire, refuse;
  logic [16:0]   last_page;

  assign last_page = {1'b0, base_page} + 17'(chain_len) - 17'd1;
  assign refuse    = (chain_len == '0) || (last_page >= 17'h0FFFF);
  assign bus_valid = (phase != P_IDLE);
  assign fire      = bus_valid && bus_ready;
  assign bus_read  = (phase == P_PRE) && (sub == 3'd0);

  always_comb begin
    bus_cmd  = 1'b1;
    bus_data = 16'h0000;
    unique case (phase)
      P_PRE: unique case (sub)
        3'd1:    bus_data = C_SEL_DSEL;
        3'd2:    begin bus_cmd = 1'b0; bus_data = V_ALL_ONES; end
        3'd3:    bus_data = C_SEL_CTRL;
        3'd4:    bus_cmd = 1'b0;
        default: bus_data = 16'h0000;
      endcase
      P_LOOP: unique case (sub)
        3'd0:    bus_data = C_SEL_PAGE;
        3'd1:    begin bus_cmd = 1'b0; bus_data = base_q + 16'(dev); end
        default: bus_data = C_FULL_SET;
      endcase
      P_POST: unique case (sub)
        3'd0, 3'd2: bus_data = C_SEL_CTRL;
        3'd1:    bus_cmd = 1'b0;
        3'd3:    begin bus_cmd = 1'b0; bus_data = V_RUN_CTRL; end
        3'd4:    bus_data = C_SEL_SEG;
        3'd5:    begin bus_cmd = 1'b0; bus_data = V_SEG_CTRL; end
        default: bus_data = C_MATCH_RD;
      endcase
      default: bus_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= P_IDLE;
      sub    <= '0;
      dev    <= '0;
      len_q  <= '0;
      base_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (phase)
        P_IDLE: if (start) begin
          if (refuse) err <= 1'b1;
          else begin
            phase  <= P_PRE;
            sub    <= '0;
            dev    <= '0;
            len_q  <= chain_len;
            base_q <= base_page;
          end
        end
        P_PRE: if (fire) begin
          if (sub == 3'd4) begin phase <= P_LOOP; sub <= '0; end
          else sub <= sub + 3'd1;
        end
        P_LOOP: if (fire) begin
          if (sub == 3'd1 && len_q == CW'(1)) begin phase <= P_POST; sub <= '0; end
          else if (sub == 3'd2) begin
            sub <= '0;
            if (dev == len_q - CW'(1)) phase <= P_POST;
            else dev <= dev + CW'(1);
          end else sub <= sub + 3'd1;
        end
        default: if (fire) begin
          if (sub == 3'd6) begin phase <= P_IDLE; sub <= '0; done <= 1'b1; end
          else sub <= sub + 3'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cam_chain_init_chk.sv
module cam_chain_init_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_ready,
  input logic        bus_cmd,
  input logic        bus_read,
  input logic [15:0] bus_data,
  input logic        done,
  input logic        err
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_data) && $stable(bus_cmd) && $stable(bus_read)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_valid && $past(bus_valid && bus_ready && bus_cmd && bus_data == 16'h0300)); // R7
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !bus_valid && !done); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R8
  AST_READ_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read |-> bus_cmd && bus_valid && bus_data == 16'h0000); // R10
  AST_READ_THEN_DSEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && bus_ready |=> !bus_read && bus_cmd && bus_data == 16'h0100); // R2
endmodule

bind cam_chain_init cam_chain_init_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_cmd(bus_cmd), .bus_read(bus_read), .bus_data(bus_data),
  .done(done), .err(err)
);

// File: tb/cam_chain_init_tb_top.sv
module cam_chain_init_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCASE = 7;
  // {chain length, base page, expect refusal}
  localparam logic [20:0] CASES [NCASE] = '{
    {4'd3,  16'h1000, 1'b0},
    {4'd1,  16'h0040, 1'b0},
    {4'd5,  16'hFFF0, 1'b0},
    {4'd2,  16'hFFFD, 1'b0},
    {4'd15, 16'h0000, 1'b0},
    {4'd2,  16'hFFFE, 1'b1},
    {4'd0,  16'h0000, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bus_ready = 1'b0;
  logic [3:0]  chain_len = '0;
  logic [15:0] base_page = '0;
  logic bus_valid, bus_cmd, bus_read, done, err;
  logic [15:0] bus_data;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_chain_init #(.CW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chain_len(chain_len),
    .base_page(base_page), .bus_ready(bus_ready), .bus_valid(bus_valid),
    .bus_cmd(bus_cmd), .bus_read(bus_read), .bus_data(bus_data),
    .done(done), .err(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  function automatic int seq_len(input int n);
    return 5 + ((n == 1) ? 2 : 3 * n) + 7;
  endfunction

  // returns {cmd, read, data}
  function automatic logic [17:0] exp_word(input int idx, input int n, input logic [15:0] b);
    int loopn, j, g;
    logic [15:0] pre [5];
    logic [17:0] post [7];
    loopn = (n == 1) ? 2 : 3 * n;
    g = (n == 1) ? 2 : 3;
    pre[0] = 16'h0000; pre[1] = 16'h0100; pre[2] = 16'hFFFF; pre[3] = 16'h0101; pre[4] = 16'h0000;
    post[0] = {2'b10, 16'h0101}; post[1] = {2'b00, 16'h0000}; post[2] = {2'b10, 16'h0101};
    post[3] = {2'b00, 16'h8040}; post[4] = {2'b10, 16'h0103}; post[5] = {2'b00, 16'h3808};
    post[6] = {2'b10, 16'h0300};
    if (idx < 5) return {idx[0] == 1'b0 && idx != 2 && idx != 4 || idx == 1 || idx == 3,
                         idx == 0, pre[idx]};
    if (idx < 5 + loopn) begin
      j = idx - 5;
      case (j % g)
        0: return {2'b10, 16'h0102};
        1: return {2'b00, b + 16'(j / g)};
        default: return {2'b10, 16'h0200};
      endcase
    end
    return post[idx - 5 - loopn];
  endfunction

  function automatic string tag_of(input int idx, input int n);
    if (idx == 0) return "R10";
    if (idx < 5) return "R2";
    if (idx < 5 + ((n == 1) ? 2 : 3 * n)) return (n == 1) ? "R4" : "R3";
    return "R5";
  endfunction

  task automatic run_case(input int n, input logic [15:0] b, input bit e, input bit stall);
    int idx = 0, t = 0, tot = seq_len(n);
    bit poked = 0;
    logic [17:0] w;
    @(negedge clk);
    chain_len = 4'(n); base_page = b; start = 1'b1; bus_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (e) begin
      chk(err === 1'b1, "R8", "err on refused start", 32'(err), 1);
      chk(bus_valid === 1'b0, "R8", "no word on refused start", 32'(bus_valid), 0);
      @(negedge clk);
      chk(err === 1'b0 && bus_valid === 1'b0, "R8", "err pulse length/valid", {err, bus_valid}, 0);
      return;
    end
    chk(err === 1'b0, "R8", "no err on legal start", 32'(err), 0);
    while (idx < tot) begin
      start = 1'b0;
      if (stall && idx == 4 && !poked) begin start = 1'b1; poked = 1; end // R9
      bus_ready = stall ? ((t % 3) != 0) : 1'b1;
      w = exp_word(idx, n, b);
      chk(bus_valid === 1'b1 && {bus_cmd, bus_read, bus_data} === w,
          stall ? "R6" : tag_of(idx, n), $sformatf("word %0d", idx),
          {13'd0, bus_valid, bus_cmd, bus_read, bus_data}, {14'd1, w});
      if (bus_ready) idx++;
      t++;
      @(negedge clk);
    end
    start = 1'b0; bus_ready = 1'b0;
    chk(done === 1'b1 && bus_valid === 1'b0, "R7", "done after last word", {done, bus_valid}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0, stall ? "R9" : "R7", "done single pulse", 32'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_valid === 0 && done === 0 && err === 0, "R1", "reset outputs", {bus_valid, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_valid === 0 && done === 0 && err === 0, "R1", "idle after reset", {bus_valid, done, err}, 0);

    for (int k = 0; k < NCASE; k++)
      run_case(int'(CASES[k][20:17]), CASES[k][16:1], CASES[k][0], 1'b0);

    run_case(4, 16'h0200, 1'b0, 1'b1);
    run_case(1, 16'h7777, 1'b0, 1'b1);

    @(negedge clk);
    chain_len = 4'd3; base_page = 16'h0010; start = 1'b1; bus_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_valid === 0 && done === 0, "R1", "reset mid-run clears", {bus_valid, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(bus_valid === 0 && done === 0 && err === 0, "R1", "idle without start", {bus_valid, done, err}, 0);

    run_case(2, 16'h0000, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule